// File: doc/BRIEF.md
# Modular Three-Operand Polynomial Adder

This block walks a 256-coefficient polynomial once and, at every index, adds three 12-bit values: a partial-sum coefficient, an error coefficient and a coefficient derived from one message bit. The sum is reduced modulo 3329 and written back to the same index in the partial-sum bank. The message bit decides the third operand. A set bit gives 1665 and a clear bit gives 0.

The partial-sum bank and the error bank are separate dual-port memories outside the block, so both reads use one shared address and take place in the same cycle. Both banks have a fixed one-cycle read latency. The write back uses the second port of the partial-sum bank. A one-cycle `start` pulse begins a pass, and a one-cycle `done` pulse ends it.

The controller has four states:
- `ST_IDLE`: waits for `start`.
- `ST_SCAN`: issues one read address per cycle.
- `ST_DRAIN`: lets the last read complete and be written.
- `ST_DONE`: signals completion.

Its transitions are:
- `ST_IDLE` goes to `ST_SCAN` when `start` is sampled.
- `ST_SCAN` goes to `ST_DRAIN` once index 255 has been issued.
- `ST_DRAIN` goes to `ST_DONE` on the write of index 255.
- `ST_DONE` always goes back to `ST_IDLE`.

Top module: `polyadd3_mod`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a pass, `busy`, `done`, `rd_en` and `wr_en` are all 0.
- R2: A `start` sampled while idle begins a pass. From the next cycle, `rd_en` is high for 256 consecutive cycles, and `rd_addr` runs 0, 1, …, 255, one value per cycle.
- R3: Every read of index i is followed, exactly one cycle later, by a write with `wr_en`=1 and `wr_addr`=i. Each pass makes exactly 256 writes, and there are no writes at any other time.
- R4: `wr_data` = (ps + er + mu) mod 3329, where ps and er are the two bank values read for that index (each below 3329). This holds up to the worst case 3328+3328+1665, which gives 1663.
- R5: mu for index i is 1665 when bit i of `msg` is 1, and 0 when that bit is 0. Bit 0 belongs to index 0.
- R6: `done` is high for exactly one cycle. It comes one cycle after the write of index 255, which is 257 clock edges after the edge that samples `start`.
- R7: `start` has no effect while a pass is running. The pass keeps its timing and its results, and no second pass follows it.
- R8: `msg` is captured on the edge that samples `start`. Later changes to `msg` during the pass do not alter any written value.
- R9: `busy` is high from the cycle after `start` is sampled up to and including the `done` cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a pass when idle |
| msg | input | 256 | Message bits; bit i selects the third operand of index i |
| rd_en | output | 1 | Read enable for both banks |
| rd_addr | output | 8 | Read address shared by both banks |
| ps_rd_data | input | 12 | Partial-sum bank read data, one cycle after `rd_en` |
| er_rd_data | input | 12 | Error bank read data, one cycle after `rd_en` |
| wr_en | output | 1 | Write enable for the partial-sum bank |
| wr_addr | output | 8 | Write address for the partial-sum bank |
| wr_data | output | 12 | Reduced sum written back |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Take the edge that samples `start` as edge 0:
- The read of index i comes on edge i+1.
- The write of index i appears one cycle after that read, so the bench pairs every `wr_addr` with the `rd_addr` of the cycle before.
- `done` is due exactly 257 edges after edge 0. The bench counts cycles from the start edge and compares the count at which `done` rises with that figure.
- One cycle later, the bench requires `done` to be low again.

The bench samples all outputs on the falling edge, half a period after the register that drives them. It compares the memory contents only after `done`, against values it computes from the modulo formula.

// File: rtl/polyadd3_pkg.sv
package polyadd3_pkg;

    localparam int unsigned N_COEF  = 256;
    localparam int unsigned COEF_W  = 12;
    localparam int unsigned MOD_Q   = 3329;
    localparam int unsigned MU_HALF = 1665;
    localparam int unsigned RD_LAT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } pa_state_e;

endpackage

// File: rtl/polyadd3_idx_ctr.sv
module polyadd3_idx_ctr #(
    parameter int unsigned N  = 256,
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [IW-1:0] idx,
    output logic          last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IW'(N - 1));

endmodule

// File: rtl/polyadd3_lat_align.sv
module polyadd3_lat_align #(
    parameter int unsigned LAT = 1,
    parameter int unsigned AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    output logic          out_vld,
    output logic [AW-1:0] out_addr
);

    // Each stage holds a valid bit above its address.
    logic [AW:0] pipe [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(LAT); k++) begin
                pipe[k] <= '0;
            end
        end else begin
            pipe[0] <= {in_vld, in_addr};
            for (int k = 1; k < int'(LAT); k++) begin
                pipe[k] <= pipe[k-1];
            end
        end
    end

    assign out_vld  = pipe[LAT-1][AW];
    assign out_addr = pipe[LAT-1][AW-1:0];

endmodule

// File: rtl/polyadd3_modred.sv
module polyadd3_modred #(
    parameter int unsigned W    = 12,
    parameter int unsigned SW   = 14,
    parameter int unsigned Q    = 3329,
    parameter int unsigned NSUB = 2
) (
    input  logic [SW-1:0] raw,
    output logic [W-1:0]  res
);

    localparam logic [SW-1:0] QV = SW'(Q);

    logic [SW-1:0] stg [NSUB+1];
    logic          unused_hi;

    assign stg[0] = raw;

    // One conditional subtraction per stage; NSUB stages cover inputs below (NSUB+1)*Q.
    for (genvar g = 0; g < int'(NSUB); g++) begin : g_sub
        assign stg[g+1] = (stg[g] >= QV) ? (stg[g] - QV) : stg[g];
    end

    assign res       = stg[NSUB][W-1:0];
    assign unused_hi = |stg[NSUB][SW-1:W];

endmodule

// File: rtl/polyadd3_mod.sv
module polyadd3_mod
    import polyadd3_pkg::*;
#(
    parameter  int unsigned N   = N_COEF,
    parameter  int unsigned W   = COEF_W,
    parameter  int unsigned Q   = MOD_Q,
    parameter  int unsigned MU  = MU_HALF,
    parameter  int unsigned LAT = RD_LAT,
    localparam int unsigned IW  = $clog2(N),
    localparam int unsigned SW  = W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  msg,
    output logic          rd_en,
    output logic [IW-1:0] rd_addr,
    input  logic [W-1:0]  ps_rd_data,
    input  logic [W-1:0]  er_rd_data,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          busy,
    output logic          done
);

    pa_state_e     state_q, state_d;
    logic [N-1:0]  msg_q;
    logic [IW-1:0] idx;
    logic          idx_last;
    logic          accept;
    logic          wr_last;
    logic [W-1:0]  mu_val;
    logic [SW-1:0] raw_sum;

    assign accept = (state_q == ST_IDLE) && start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_SCAN;
            ST_SCAN:  if (idx_last) state_d = ST_DRAIN;
            ST_DRAIN: if (wr_last)  state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        rd_en = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy  = 1'b0;
            ST_SCAN:  rd_en = 1'b1;
            ST_DRAIN: ;
            ST_DONE:  done  = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    // Message captured once per pass
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else if (accept) begin
            msg_q <= msg;
        end
    end

    polyadd3_idx_ctr #(.N(N), .IW(IW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .adv   (rd_en),
        .idx   (idx),
        .last  (idx_last)
    );

    assign rd_addr = idx;

    polyadd3_lat_align #(.LAT(LAT), .AW(IW)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_en),
        .in_addr  (rd_addr),
        .out_vld  (wr_en),
        .out_addr (wr_addr)
    );

    assign wr_last = wr_en && (wr_addr == IW'(N - 1));
    assign mu_val  = msg_q[wr_addr] ? W'(MU) : '0;
    assign raw_sum = SW'(ps_rd_data) + SW'(er_rd_data) + SW'(mu_val);

    polyadd3_modred #(.W(W), .SW(SW), .Q(Q), .NSUB(2)) u_red (
        .raw (raw_sum),
        .res (wr_data)
    );

endmodule

// File: rtl/polyadd3_chk.sv
module polyadd3_chk #(
    parameter int unsigned N  = 256,
    parameter int unsigned IW = 8,
    parameter int unsigned W  = 12,
    parameter int unsigned Q  = 3329
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_en,
    input logic [IW-1:0] rd_addr,
    input logic          wr_en,
    input logic [IW-1:0] wr_addr,
    input logic [W-1:0]  wr_data,
    input logic          busy,
    input logic          done
);

    // R2
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == IW'($past(rd_addr) + 1'b1)));

    // R3
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (wr_en && (wr_addr == $past(rd_addr))));

    // R3
    no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !wr_en);

    // R4
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data < W'(Q)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_addr) == IW'(N - 1))));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

bind polyadd3_mod polyadd3_chk #(.N(N), .IW(IW), .W(W), .Q(Q)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .done    (done)
);

// File: tb/polyadd3_mod_tb.sv
`timescale 1ns/1ps
module polyadd3_mod_tb;

    localparam int NC = 256;
    localparam int QQ = 3329;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NC-1:0] msg = '0;
    logic          rd_en, wr_en, busy, done;
    logic [7:0]    rd_addr, wr_addr;
    logic [11:0]   ps_q = '0, er_q = '0, wr_data;

    logic [11:0] ps_mem [NC];
    logic [11:0] er_mem [NC];
    int          exp_v  [NC];

    int total = 0;
    int bad   = 0;

    int mon_on = 0, rd_cnt = 0, wr_cnt = 0, seq_err = 0;
    logic       prev_rd = 1'b0;
    logic [7:0] prev_addr = '0;

    always #2.5 clk = ~clk;

    polyadd3_mod u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .msg        (msg),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .ps_rd_data (ps_q),
        .er_rd_data (er_q),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .done       (done)
    );

    // Bank models: one-cycle read, in-place write on the partial-sum bank
    always @(posedge clk) begin
        if (rd_en) begin
            ps_q <= ps_mem[rd_addr];
            er_q <= er_mem[rd_addr];
        end
        if (wr_en) ps_mem[wr_addr] <= wr_data;
    end

    // Port-sequence monitor (R2, R3)
    always @(negedge clk) begin
        if (mon_on != 0) begin
            if (wr_en !== prev_rd) seq_err++;
            if (wr_en) begin
                if (wr_addr !== prev_addr) seq_err++;
                wr_cnt++;
            end
            if (rd_en) begin
                if (rd_addr !== 8'(rd_cnt)) seq_err++;
                rd_cnt++;
            end
            prev_rd   = rd_en;
            prev_addr = rd_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int fillv(int mode, int seed, int i);
        case (mode)
            0:       return 0;
            1:       return QQ - 1;
            2:       return (i * seed + 7) % QQ;
            default: return QQ - 1 - ((i * 37 + seed) % QQ);
        endcase
    endfunction

    function automatic bit msgbit(int mode, int seed, int i);
        case (mode)
            0:       return 1'b0;
            1:       return 1'b1;
            2:       return 1'(i % 2);
            default: return 1'(((i * seed) >> 2) & 1);
        endcase
    endfunction

    // Vector table: {ps mode, err mode, msg mode, seed}
    localparam logic [13:0] VT [6] = '{
        {2'd0, 2'd0, 2'd0, 8'd0},
        {2'd1, 2'd1, 2'd1, 8'd0},
        {2'd1, 2'd0, 2'd0, 8'd0},
        {2'd2, 2'd2, 2'd2, 8'd13},
        {2'd2, 2'd3, 2'd3, 8'd101},
        {2'd0, 2'd1, 2'd1, 8'd0}
    };

    // Loads banks, runs one pass, checks timing, sequence and data.
    task automatic run_pass(input int v, input int flip_at, input int poke_at, input string tag);
        int pm, em, mm, sd, cyc, dmis, last_bad;
        logic [NC-1:0] mv;
        pm = int'(VT[v][13:12]); em = int'(VT[v][11:10]);
        mm = int'(VT[v][9:8]);   sd = int'(VT[v][7:0]);
        for (int i = 0; i < NC; i++) begin
            ps_mem[i] = 12'(fillv(pm, sd, i));
            er_mem[i] = 12'(fillv(em, sd + 3, i));
            mv[i]     = msgbit(mm, sd, i);
            exp_v[i]  = (int'(ps_mem[i]) + int'(er_mem[i]) + (mv[i] ? 1665 : 0)) % QQ;
        end
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; seq_err = 0; prev_rd = 1'b0; mon_on = 1;
        msg = mv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy === 1'b1, {"R9 busy after start ", tag}, int'(busy), 1);
        while (done !== 1'b1 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            start = (cyc == poke_at) ? 1'b1 : 1'b0;
            if (cyc == flip_at) msg = ~msg;
        end
        start = 1'b0;
        // done is due 257 edges after the start edge -> negedge count 258
        chk(cyc == 258, {"R6 done timing ", tag}, cyc, 258);
        @(negedge clk);
        mon_on = 0;
        chk(done === 1'b0 && busy === 1'b0, {"R6/R9 done one cycle ", tag}, int'(done), 0);
        chk(seq_err == 0 && rd_cnt == NC && wr_cnt == NC,
            {"R2/R3 read/write sequence ", tag}, wr_cnt + 1000 * seq_err, NC);
        dmis = 0; last_bad = 0;
        for (int i = 0; i < NC; i++) begin
            if (int'(ps_mem[i]) != exp_v[i]) begin
                dmis++;
                last_bad = i;
            end
        end
        chk(dmis == 0, {"R4/R5 written values ", tag}, int'(ps_mem[last_bad]), exp_v[last_bad]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0,
            "R1 reset state", int'({busy, done, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && wr_en === 1'b0, "R1 idle after release", int'({busy, wr_en}), 0);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 6; v++) begin
            run_pass(v, -1, -1, $sformatf("vec%0d", v));
        end

        // R8: message inverted mid-pass must not change results
        run_pass(3, 60, -1, "r8_msg_flip");

        // R7: start pulsed mid-pass, then no second pass
        run_pass(4, 100, 120, "r7_start_busy");
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (busy || wr_en || rd_en) extra++;
            end
            chk(extra == 0, "R7 no second pass", extra, 0);
        end

        // R1: reset asserted mid-pass
        for (int i = 0; i < NC; i++) begin
            ps_mem[i] = 12'd5;
            er_mem[i] = 12'd6;
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0,
            "R1 reset mid-pass", int'({busy, done, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ps_mem[200] === 12'd5, "R1 no writes after reset", int'(ps_mem[200]), 5);

        // A pass after the interrupted one still behaves
        run_pass(1, -1, -1, "after_reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule